// File: doc/BRIEF.md
# NAND Access Width Adapter

This block converts one host access into the sequence of device bus cycles needed to reach a NAND-style flash part. A host access can be 8, 16 or 32 bits wide. The attached part has either an 8-bit or a 16-bit bus, and the block issues as many device cycles as the two widths require. It sends the lowest-order piece of the host word first.

Three host windows select the kind of transfer. A command-window write raises only the command latch line and an address-window write raises only the address latch line. A data-window access raises neither latch line, and only the data window can be read. Read data from the device cycles is packed into a host word, with the first cycle in the lowest bits.

The host port holds `host_ready` low until the last device cycle has finished. Every access is ignored unless the chip select is configured as a NAND-type device.

Top module: `nand_width_adapter`

## Requirements
- R1: With `cfg_devsize[0]`=0 (byte device), the number of device cycles follows `host_size`: 2'b00 (8-bit) gives 1, 2'b01 (16-bit) gives 2, 2'b1x (32-bit) gives 4. Cycle k drives `host_wdata[8k+7:8k]` on `dev_wdata[7:0]` with `dev_wdata[15:8]`=0.
- R2: With `cfg_devsize[0]`=1 (halfword device), a 32-bit access gives 2 cycles and a 16-bit access gives 1 cycle. Cycle k drives `host_wdata[16k+15:16k]`, so the low halfword goes first.
- R3: An 8-bit access to a halfword device makes exactly one device cycle. A write drives `host_wdata[15:0]` unchanged, and a read returns only the low byte of `dev_rdata`.
- R4: `host_win` selects the window. 2'b00 is data and raises neither latch line. 2'b01 is command and raises `dev_cle` only. 2'b10 is address and raises `dev_ale` only. During every device cycle `dev_we` is high for writes and `dev_re` is high for reads, never both.
- R5: Reads of the command or address window, and any access with `host_win`=2'b11, make no device cycle. Such a read returns `host_rdata`=0.
- R6: Only `cfg_devsize[0]` selects the device width, and `cfg_devsize[1]` has no effect. Codes 2'b10 and 2'b11 behave as 2'b00 and 2'b01.
- R7: Unless `cfg_devtype`=2'b10 (NAND), every access is ignored. No device cycle occurs, `host_ready` stays high, and reads return 0.
- R8: A device cycle completes on a rising edge where `dev_req` and `dev_ack` are both high, and its control and data outputs stay stable until then. `host_ready` falls the cycle after a valid request is accepted and rises the cycle after the last handshake.
- R9: Read data is packed little-endian. Device cycle k fills byte k on a byte device and halfword k on a halfword device.
- R10: Bits of `host_rdata` above the access size are zero.
- R11: After reset `host_ready`=1, `dev_req`=0 and `host_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_devtype | input | 2 | Chip-select device type, 2'b10 = NAND |
| cfg_devsize | input | 2 | Device width code, bit 0 = halfword bus |
| host_req | input | 1 | Access request, accepted when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_win | input | 2 | Window: data, command, address, none |
| host_size | input | 2 | Access size: 8, 16 or 32 bits |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read result, valid once `host_ready` returns |
| host_ready | output | 1 | Idle and able to accept a request |
| dev_req | output | 1 | Device cycle in progress |
| dev_cle | output | 1 | Command latch enable |
| dev_ale | output | 1 | Address latch enable |
| dev_we | output | 1 | Write strobe |
| dev_re | output | 1 | Read strobe |
| dev_wdata | output | 16 | Data driven to the device |
| dev_rdata | input | 16 | Data returned by the device, sampled with `dev_ack` |
| dev_ack | input | 1 | Device completes the current cycle |

## Verification
The assertions assume that `cfg_devtype` and `cfg_devsize` do not change while `host_ready` is low. They also assume that `dev_ack` is high only while `dev_req` is high. The stimulus keeps to both assumptions: it changes the configuration only between accesses, and its device model acknowledges only a pending cycle, on every other clock. The sweep covers every configuration code, size, window and direction.

// File: rtl/nand_width_adapter.sv
module nand_width_adapter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cfg_devtype,
  input  logic [1:0]  cfg_devsize,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [1:0]  host_win,
  input  logic [1:0]  host_size,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_ready,
  output logic        dev_req,
  output logic        dev_cle,
  output logic        dev_ale,
  output logic        dev_we,
  output logic        dev_re,
  output logic [15:0] dev_wdata,
  input  logic [15:0] dev_rdata,
  input  logic        dev_ack
);
  localparam logic [1:0] TYPE_NAND = 2'b10;
  localparam logic [1:0] WIN_DATA  = 2'b00;
  localparam logic [1:0] WIN_CMD   = 2'b01;
  localparam logic [1:0] WIN_ADDR  = 2'b10;
  localparam logic [1:0] WIN_NONE  = 2'b11;

  logic        busy, we_q, wide_q;
  logic [1:0]  win_q, size_q, beat, last_q, last_calc;
  logic [31:0] wbuf, rbuf, rnext, rmask;
  logic        take;

  assign take = host_req && cfg_devtype == TYPE_NAND && host_win != WIN_NONE &&
                (host_we || host_win == WIN_DATA);

  always_comb begin
    if (cfg_devsize[0]) last_calc = host_size[1] ? 2'd1 : 2'd0;
    else                last_calc = host_size[1] ? 2'd3 : (host_size[0] ? 2'd1 : 2'd0);
  end

  always_comb begin
    rnext = rbuf;
    if (wide_q) rnext[{beat[0], 4'b0000} +: 16] = dev_rdata;
    else        rnext[{beat, 3'b000} +: 8] = dev_rdata[7:0];
  end

  assign rmask = size_q[1] ? rnext :
                 size_q[0] ? {16'h0000, rnext[15:0]} : {24'h000000, rnext[7:0]};

  always_comb begin
    if (wide_q) dev_wdata = wbuf[{beat[0], 4'b0000} +: 16];
    else        dev_wdata = {8'h00, wbuf[{beat, 3'b000} +: 8]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; we_q <= 1'b0; wide_q <= 1'b0; win_q <= WIN_DATA;
      size_q <= 2'b00; beat <= 2'd0; last_q <= 2'd0;
      wbuf <= '0; rbuf <= '0; host_rdata <= '0;
    end else if (!busy) begin
      if (take) begin
        busy   <= 1'b1;
        we_q   <= host_we;
        win_q  <= host_win;
        size_q <= host_size;
        wide_q <= cfg_devsize[0];
        last_q <= last_calc;
        beat   <= 2'd0;
        wbuf   <= host_wdata;
        rbuf   <= '0;
      end else if (host_req && !host_we) begin
        host_rdata <= '0;
      end
    end else if (dev_ack) begin
      rbuf <= rnext;
      beat <= beat + 2'd1;
      if (beat == last_q) begin
        busy <= 1'b0;
        if (!we_q) host_rdata <= rmask;
      end
    end
  end

  assign host_ready = !busy;
  assign dev_req    = busy;
  assign dev_cle    = busy && win_q == WIN_CMD;
  assign dev_ale    = busy && win_q == WIN_ADDR;
  assign dev_we     = busy && we_q;
  assign dev_re     = busy && !we_q;
endmodule

module nand_width_adapter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cfg_devtype,
  input logic        host_req,
  input logic        host_ready,
  input logic        dev_req,
  input logic        dev_cle,
  input logic        dev_ale,
  input logic        dev_we,
  input logic        dev_re,
  input logic [15:0] dev_wdata,
  input logic        dev_ack
);
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> !(dev_cle && dev_ale)); // R4
  AST_DIR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> (dev_we != dev_re)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_req |-> !(dev_cle || dev_ale || dev_we || dev_re)); // R8
  AST_READ_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    dev_re |-> !(dev_cle || dev_ale)); // R5
  AST_STALL_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |-> !host_ready); // R8
  AST_NON_NAND: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && cfg_devtype != 2'b10) |=> host_ready); // R7
  AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !dev_ack) |=> dev_req && $stable(dev_wdata) && $stable(dev_cle)
      && $stable(dev_ale) && $stable(dev_we)); // R8
endmodule

bind nand_width_adapter nand_width_adapter_chk chk (.*);

// File: tb/nand_width_adapter_test.sv
module nand_width_adapter_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_devtype = 2'b00, cfg_devsize = 2'b00, host_win = 2'b00, host_size = 2'b00;
  logic host_req = 1'b0, host_we = 1'b0, dev_ack = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic host_ready, dev_req, dev_cle, dev_ale, dev_we, dev_re;
  logic [15:0] dev_wdata, dev_rdata = '0, rbase = '0;
  int n_chk = 0, n_bad = 0, n_beat = 0, cyc = 0;
  bit done = 0;
  logic [19:0] blog [8];

  always #2 clk = ~clk;

  nand_width_adapter uut (.*);

  always @(negedge clk) begin
    if (dev_req && !dev_ack) begin
      if (n_beat < 8) blog[n_beat] = {dev_cle, dev_ale, dev_we, dev_re, dev_wdata};
      dev_rdata = rbase + 16'(n_beat) * 16'h0101;
      n_beat++;
      dev_ack = 1'b1;
    end else begin
      dev_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 actual=%h expected=%h", cyc, 0);
      finish_run();
    end
  end

  task automatic access(input int acc, input logic [1:0] dt, input logic [1:0] ds,
                        input logic [1:0] sz, input logic we, input logic [1:0] win);
    logic [31:0] wd, er;
    logic [15:0] rk, ew;
    logic [3:0] ectl;
    bit valid, wide;
    int nb, n;
    wd = {8'(acc), 8'hA5 ^ 8'(acc), 8'(acc * 3), 8'h3C + 8'(acc)};
    valid = dt == 2'b10 && win != 2'b11 && (we || win == 2'b00);
    wide = ds[0];
    nb = !valid ? 0 : wide ? (sz == 2'd2 ? 2 : 1) : (sz == 2'd2 ? 4 : (sz == 2'd1 ? 2 : 1));
    @(negedge clk);
    rbase = 16'(acc) * 16'h0731 + 16'h1234;
    n_beat = 0;
    cfg_devtype = dt; cfg_devsize = ds; host_size = sz; host_we = we;
    host_win = win; host_wdata = wd; host_req = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      host_req = 1'b0;
      n++;
    end while (!host_ready && n < 50);
    chk(n_beat == nb, valid ? (wide ? "R2 R3 R6 count" : "R1 R6 count") : "R5 R7 no cycles",
        32'(n_beat), 32'(nb));
    chk(n == (valid ? 2 * nb : 1), "R8 ready timing", 32'(n), 32'(valid ? 2 * nb : 1));
    for (int k = 0; k < nb && k < n_beat && k < 8; k++) begin
      ectl = {win == 2'b01, win == 2'b10, we, !we};
      ew = wide ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
      chk(blog[k][19:16] == ectl, "R4 latch and strobe", 32'(blog[k][19:16]), 32'(ectl));
      if (we) chk(blog[k][15:0] == ew, wide ? "R2 R3 write lane" : "R1 write lane",
                  32'(blog[k][15:0]), 32'(ew));
    end
    if (!we) begin
      er = '0;
      for (int k = 0; k < nb; k++) begin
        rk = rbase + 16'(k) * 16'h0101;
        if (wide) er[16*k +: 16] = rk; else er[8*k +: 8] = rk[7:0];
      end
      if (sz == 2'd0) er = {24'h0, er[7:0]};
      else if (sz == 2'd1) er = {16'h0, er[15:0]};
      chk(host_rdata == er, valid ? "R9 R10 R3 read data" : "R5 R7 read zero", host_rdata, er);
    end
  endtask

  initial begin
    int acc;
    repeat (3) @(negedge clk);
    chk(host_ready === 1'b1 && dev_req === 1'b0, "R11 reset idle",
        {30'h0, host_ready, dev_req}, 32'h2);
    chk(host_rdata === 32'h0, "R11 reset rdata", host_rdata, 32'h0);
    rst_n = 1'b1;
    acc = 0;
    for (int dt = 0; dt < 4; dt++)
      for (int ds = 0; ds < 4; ds++)
        for (int sz = 0; sz < 3; sz++)
          for (int we = 0; we < 2; we++)
            for (int win = 0; win < 4; win++) begin
              access(acc, 2'(dt), 2'(ds), 2'(sz), 1'(we), 2'(win));
              acc++;
            end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule